// File: doc/BRIEF.md
# Flash Write Address Capture Unit

This block is the device-side front end of a flash part whose address and data share one bus. The host begins each write by presenting an address and then puts the data word on the same wires. The block decides which address each data word belongs to and hands the pair to the array logic as a single registered commit. All bus pins are sampled by a free-running internal clock `clk`. The host's bus clock arrives as an ordinary input, so the unit still works when the host stops that clock.

An address can arrive in four ways. In synchronous mode it can come from the first bus-clock rising edge seen while the address-valid strobe is low, or from the rising edge of that strobe, whichever comes first. In synchronous mode it can also come from a bus value held steady for a programmable number of samples before the write strobe rises, which covers the case where the bus clock is stopped and the strobe stays low. Finally, when the strobe stays high and only chip-enable or write-enable toggles, no new address arrives and the last stored one is used again. In asynchronous mode only the strobe's rising edge captures an address. Two sticky flags report a commit attempted with no valid address and a stable-bus capture whose hold window was too short.

Top module: `flash_wr_addr_capture`

## Requirements
- R1: After a synchronous reset, `wr_commit` is 0, `wr_addr` and `wr_data` are 0, both error flags are 0, and no address is valid.
- R2: With `cfg_async`=0, the first `bus_clk` rising edge sampled while `adv_n` is low captures `ad_bus` as the address. Later `bus_clk` edges and the `adv_n` rising edge in the same low window leave it unchanged.
- R3: With `cfg_async`=0, if no `bus_clk` edge captured an address during an `adv_n` low window, the rising edge of `adv_n` captures the bus value sampled while `adv_n` was still low.
- R4: With `cfg_async`=1, `bus_clk` edges never capture. Only the rising edge of `adv_n` captures, using the bus value from the last low sample.
- R5: A commit occurs when `we_n` or `ce_n` rises after both were low. `wr_commit` pulses high for exactly one `clk` cycle, two `clk` edges after the rise is sampled. `wr_data` is the bus value sampled just before the rise, and `wr_addr` is the bound address. Ending the write with `ce_n` works the same as ending it with `we_n`.
- R6: When `adv_n` stays high between writes, each commit reuses the most recently captured address.
- R7: With `cfg_async`=0, when `adv_n` falls and then stays low with no `bus_clk` edge until a commit, the bus value held unchanged for at least `HOLD_CYC` samples before the rise becomes both the address and the data of that commit.
- R8: In the R7 case, if the bus value was held for fewer than `HOLD_CYC` samples, the address is not updated and `err_hold` is set and stays set until reset. The commit proceeds with the previously stored address, and the `adv_n` rise that closes that window captures nothing.
- R9: A commit with no valid address produces no `wr_commit` pulse and sets `err_no_addr`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_async | input | 1 | Bit 15 of the read configuration word: 0 selects synchronous, 1 asynchronous |
| bus_clk | input | 1 | Host bus clock, may be stopped |
| adv_n | input | 1 | Active-low address-valid strobe |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| ad_bus | input | BUS_W | Shared address/data bus |
| wr_commit | output | 1 | One-cycle write commit strobe |
| wr_addr | output | BUS_W | Address bound to the committed word |
| wr_data | output | BUS_W | Committed data word |
| err_no_addr | output | 1 | Sticky: commit attempted with no valid address |
| err_hold | output | 1 | Sticky: stable-bus address held too briefly |

## Verification
The bench changes the bus to a new value in the same sample in which the `adv_n` or `we_n` strobe rises. A design that latched the current sample instead of the one before would bind the data word as the address, or junk as the data. It moves the bus between two clock edges inside one address window. Recapturing on the second edge, or letting `adv_n`'s rise overwrite a clock capture, shows up as the wrong address. It toggles `bus_clk` in asynchronous mode, where any clock capture is visible as a changed address. It also drives the stable-bus path with long and short hold runs, plus a commit before any address exists, which exposes missing or non-sticky error flags and strobes that fire without a valid address.

// File: rtl/wac_pkg.sv
package wac_pkg;

  // Which source supplied the address in the current sample
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CLK  = 2'd1,
    SRC_ADV  = 2'd2,
    SRC_BUS  = 2'd3
  } addr_src_e;

  // Edge events derived from two consecutive samples of the bus pins
  typedef struct packed {
    logic clk_rise;
    logic adv_rise;
    logic adv_fall;
    logic commit;
  } bus_evt_t;

endpackage

// File: rtl/wac_in_sample.sv
module wac_in_sample
  import wac_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_clk,
  input  logic             adv_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic [BUS_W-1:0] ad_bus,
  output bus_evt_t         evt,
  output logic             adv_lvl,
  output logic             adv_lvl_d,
  output logic [BUS_W-1:0] ad_now,
  output logic [BUS_W-1:0] ad_prev
);

  // Control pin index map: 3 bus clock, 2 adv, 1 ce, 0 we
  localparam int          NCTL    = 4;
  localparam logic [NCTL-1:0] CTL_IDLE = 4'b0111;

  logic [NCTL-1:0] ctl_in;
  logic [NCTL-1:0] ctl_s;
  logic [NCTL-1:0] ctl_d;

  assign ctl_in = {bus_clk, adv_n, ce_n, we_n};

  // Two-deep sample chain per control pin, reset to the idle level
  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_s[g] <= CTL_IDLE[g];
        ctl_d[g] <= CTL_IDLE[g];
      end else begin
        ctl_s[g] <= ctl_in[g];
        ctl_d[g] <= ctl_s[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_now  <= '0;
      ad_prev <= '0;
    end else begin
      ad_now  <= ad_bus;
      ad_prev <= ad_now;
    end
  end

  always_comb begin
    evt.clk_rise = ctl_s[3] & ~ctl_d[3];
    evt.adv_rise = ctl_s[2] & ~ctl_d[2];
    evt.adv_fall = ~ctl_s[2] & ctl_d[2];
    evt.commit   = (ctl_s[0] | ctl_s[1]) & ~ctl_d[0] & ~ctl_d[1];
  end

  assign adv_lvl   = ctl_s[2];
  assign adv_lvl_d = ctl_d[2];

  // R5: a commit event cannot repeat in the next sample
  commit_evt_single_chk: assert property (@(posedge clk) disable iff (rst)
    evt.commit |=> !evt.commit);

endmodule

// File: rtl/wac_hold_mon.sv
module wac_hold_mon #(
  parameter int BUS_W    = 16,
  parameter int HOLD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] ad_now,
  input  logic [BUS_W-1:0] ad_prev,
  output logic             hold_ok
);

  localparam int            CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] SAT = CNT_W'(HOLD_CYC - 1);

  // Count of consecutive equal sample pairs, saturating at HOLD_CYC-1
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (ad_now != ad_prev) begin
      run_cnt <= '0;
    end else if (run_cnt != SAT) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign hold_ok = (run_cnt >= SAT);

  if (HOLD_CYC > 1) begin : g_hold_chk
    // R8: a fresh bus change always leaves the hold window unmet
    hold_reset_chk: assert property (@(posedge clk) disable iff (rst)
      (ad_now != ad_prev) |=> !hold_ok);
  end

endmodule

// File: rtl/wac_addr_track.sv
module wac_addr_track
  import wac_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_mode,
  input  bus_evt_t         evt,
  input  logic             adv_lvl,
  input  logic             adv_lvl_d,
  input  logic [BUS_W-1:0] ad_now,
  input  logic [BUS_W-1:0] ad_prev,
  input  logic             hold_ok,
  output logic [BUS_W-1:0] addr_next,
  output logic             valid_next,
  output logic             hold_fail
);

  logic [BUS_W-1:0] addr_q;
  logic             valid_q;
  logic             armed_q;
  logic             armed_next;
  logic             arm_now;
  addr_src_e        src;

  always_comb begin
    arm_now   = armed_q | evt.adv_fall;
    src       = SRC_NONE;
    addr_next = addr_q;
    hold_fail = 1'b0;

    // Priority: clock edge, then strobe rise, then stable-bus hold
    if (sync_mode && evt.clk_rise && !adv_lvl && arm_now) begin
      src       = SRC_CLK;
      addr_next = ad_now;
    end else if (evt.adv_rise && armed_q) begin
      src       = SRC_ADV;
      addr_next = ad_prev;
    end else if (sync_mode && evt.commit && !adv_lvl_d && arm_now) begin
      if (hold_ok) begin
        src       = SRC_BUS;
        addr_next = ad_prev;
      end else begin
        hold_fail = 1'b1;
      end
    end

    valid_next = valid_q | (src != SRC_NONE);

    if (src != SRC_NONE || hold_fail) begin
      armed_next = 1'b0;
    end else if (evt.adv_fall) begin
      armed_next = 1'b1;
    end else if (evt.adv_rise) begin
      armed_next = 1'b0;
    end else begin
      armed_next = armed_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      addr_q  <= addr_next;
      valid_q <= valid_next;
      armed_q <= armed_next;
    end
  end

  // R4: in asynchronous mode a bus clock edge alone never moves the address
  async_clk_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode && evt.clk_rise && !evt.adv_rise) |=> $stable(addr_q));

  // R1: once valid, the address stays valid until reset
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q);

endmodule

// File: rtl/wac_commit.sv
module wac_commit #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_evt,
  input  logic [BUS_W-1:0] addr_next,
  input  logic             valid_next,
  input  logic [BUS_W-1:0] ad_prev,
  input  logic             hold_fail,
  output logic             wr_commit,
  output logic [BUS_W-1:0] wr_addr,
  output logic [BUS_W-1:0] wr_data,
  output logic             err_no_addr,
  output logic             err_hold
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_commit   <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      err_no_addr <= 1'b0;
      err_hold    <= 1'b0;
    end else begin
      wr_commit <= commit_evt & valid_next;
      if (commit_evt && valid_next) begin
        wr_addr <= addr_next;
        wr_data <= ad_prev;
      end
      if (commit_evt && !valid_next) err_no_addr <= 1'b1;
      if (hold_fail)                 err_hold    <= 1'b1;
    end
  end

  // R5
  commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit);

  // R9
  no_addr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_no_addr |=> err_no_addr);

  // R8
  hold_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_hold |=> err_hold);

  // R9: the data registers move only together with a commit strobe
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(commit_evt) |-> $stable(wr_data) || wr_commit);

endmodule

// File: rtl/flash_wr_addr_capture.sv
module flash_wr_addr_capture
  import wac_pkg::*;
#(
  parameter int BUS_W    = 16,
  parameter int HOLD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_async,
  input  logic             bus_clk,
  input  logic             adv_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic [BUS_W-1:0] ad_bus,
  output logic             wr_commit,
  output logic [BUS_W-1:0] wr_addr,
  output logic [BUS_W-1:0] wr_data,
  output logic             err_no_addr,
  output logic             err_hold
);

  bus_evt_t         evt;
  logic             adv_lvl;
  logic             adv_lvl_d;
  logic [BUS_W-1:0] ad_now;
  logic [BUS_W-1:0] ad_prev;
  logic             hold_ok;
  logic [BUS_W-1:0] addr_next;
  logic             valid_next;
  logic             hold_fail;

  wac_in_sample #(.BUS_W(BUS_W)) u_sample (
    .clk       (clk),
    .rst       (rst),
    .bus_clk   (bus_clk),
    .adv_n     (adv_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .ad_bus    (ad_bus),
    .evt       (evt),
    .adv_lvl   (adv_lvl),
    .adv_lvl_d (adv_lvl_d),
    .ad_now    (ad_now),
    .ad_prev   (ad_prev)
  );

  wac_hold_mon #(.BUS_W(BUS_W), .HOLD_CYC(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .ad_now  (ad_now),
    .ad_prev (ad_prev),
    .hold_ok (hold_ok)
  );

  wac_addr_track #(.BUS_W(BUS_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .sync_mode  (~cfg_async),
    .evt        (evt),
    .adv_lvl    (adv_lvl),
    .adv_lvl_d  (adv_lvl_d),
    .ad_now     (ad_now),
    .ad_prev    (ad_prev),
    .hold_ok    (hold_ok),
    .addr_next  (addr_next),
    .valid_next (valid_next),
    .hold_fail  (hold_fail)
  );

  wac_commit #(.BUS_W(BUS_W)) u_commit (
    .clk         (clk),
    .rst         (rst),
    .commit_evt  (evt.commit),
    .addr_next   (addr_next),
    .valid_next  (valid_next),
    .ad_prev     (ad_prev),
    .hold_fail   (hold_fail),
    .wr_commit   (wr_commit),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .err_no_addr (err_no_addr),
    .err_hold    (err_hold)
  );

endmodule

// File: tb/test_flash_wr_addr_capture.sv
`timescale 1ns/1ps
module test_flash_wr_addr_capture;

  localparam int BUS_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_async = 1'b0;
  logic             bus_clk = 1'b0;
  logic             adv_n = 1'b1;
  logic             ce_n = 1'b1;
  logic             we_n = 1'b1;
  logic [BUS_W-1:0] ad_bus = '0;
  logic             wr_commit;
  logic [BUS_W-1:0] wr_addr;
  logic [BUS_W-1:0] wr_data;
  logic             err_no_addr;
  logic             err_hold;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  flash_wr_addr_capture #(.BUS_W(BUS_W), .HOLD_CYC(4)) i_flash_wr_addr_capture (
    .clk(clk), .rst(rst), .cfg_async(cfg_async), .bus_clk(bus_clk),
    .adv_n(adv_n), .ce_n(ce_n), .we_n(we_n), .ad_bus(ad_bus),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_no_addr(err_no_addr), .err_hold(err_hold)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drives one write; returns at the sample where the commit strobe is due
  task automatic wr_cycle(input logic [BUS_W-1:0] d, input bit end_by_ce);
    we_n = 1'b0; ce_n = 1'b0; ad_bus = d;
    step(3);
    if (end_by_ce) ce_n = 1'b1; else we_n = 1'b1;
    ad_bus = 16'hBEEF;
    step(2);
  endtask

  task automatic wr_finish();
    step(1);
    we_n = 1'b1; ce_n = 1'b1;
    step(2);
  endtask

  task automatic expect_write(input string req, input logic [BUS_W-1:0] a,
                              input logic [BUS_W-1:0] d, input bit end_by_ce);
    wr_cycle(d, end_by_ce);
    chk(req, "wr_commit", 32'(wr_commit), 32'd1);
    chk(req, "wr_addr",   32'(wr_addr),   32'(a));
    chk(req, "wr_data",   32'(wr_data),   32'(d));
    step(1);
    chk("R5", "pulse width", 32'(wr_commit), 32'd0);
    we_n = 1'b1; ce_n = 1'b1;
    step(2);
  endtask

  task automatic t_reset();
    chk("R1", "wr_commit",   32'(wr_commit),   32'd0);
    chk("R1", "wr_addr",     32'(wr_addr),     32'd0);
    chk("R1", "wr_data",     32'(wr_data),     32'd0);
    chk("R1", "err_no_addr", 32'(err_no_addr), 32'd0);
    chk("R1", "err_hold",    32'(err_hold),    32'd0);
  endtask

  task automatic t_no_addr();
    wr_cycle(16'h1111, 1'b0);
    chk("R9", "no strobe", 32'(wr_commit), 32'd0);
    step(1);
    chk("R9", "err_no_addr", 32'(err_no_addr), 32'd1);
    chk("R9", "wr_data kept", 32'(wr_data), 32'd0);
    wr_finish();
  endtask

  task automatic t_sync_clk();
    adv_n = 1'b0; ad_bus = 16'hA001; step(2);
    bus_clk = 1'b1; step(2);
    bus_clk = 1'b0; ad_bus = 16'hA002; step(2);
    bus_clk = 1'b1; step(2);
    bus_clk = 1'b0; adv_n = 1'b1; ad_bus = 16'h5555; step(3);
    expect_write("R2", 16'hA001, 16'hD001, 1'b0);
  endtask

  task automatic t_sync_adv();
    adv_n = 1'b0; ad_bus = 16'hA003; step(3);
    adv_n = 1'b1; ad_bus = 16'h6666; step(3);
    expect_write("R3", 16'hA003, 16'hD003, 1'b0);
  endtask

  task automatic t_reuse();
    expect_write("R6", 16'hA003, 16'hD004, 1'b0);
    expect_write("R5", 16'hA003, 16'hD005, 1'b1);
  endtask

  task automatic t_async();
    cfg_async = 1'b1; step(1);
    adv_n = 1'b0; ad_bus = 16'hA005; step(2);
    bus_clk = 1'b1; step(2);
    bus_clk = 1'b0; ad_bus = 16'hA006; step(2);
    adv_n = 1'b1; ad_bus = 16'h7777; step(3);
    expect_write("R4", 16'hA006, 16'hD006, 1'b0);
    cfg_async = 1'b0; step(1);
  endtask

  task automatic t_stable();
    adv_n = 1'b0; ad_bus = 16'hA007; step(8);
    expect_write("R7", 16'hA007, 16'hA007, 1'b0);
    adv_n = 1'b1; step(3);
    chk("R7", "err_hold clear", 32'(err_hold), 32'd0);
  endtask

  task automatic t_short();
    adv_n = 1'b0; ad_bus = 16'hB000; step(1);
    expect_write("R8", 16'hA007, 16'hB001, 1'b0);
    chk("R8", "err_hold set", 32'(err_hold), 32'd1);
    adv_n = 1'b1; ad_bus = 16'h8888; step(3);
    expect_write("R8", 16'hA007, 16'hD008, 1'b0);
    chk("R8", "err_hold sticky", 32'(err_hold), 32'd1);
    chk("R9", "err_no_addr sticky", 32'(err_no_addr), 32'd1);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(2);
    t_reset();
    t_no_addr();
    t_sync_clk();
    t_sync_adv();
    t_reuse();
    t_async();
    t_stable();
    t_short();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule